// File: doc/BRIEF.md
# Tightly-Coupled Memory Address Router

This block sits between a processor's two memory ports and three possible targets: a local instruction RAM, a local data RAM and the external system bus. It looks at each request address and steers it by the top bits. The lowest 64MB window belongs to the instruction RAM and the next 64MB window belongs to the data RAM. Everything from 128MB upward goes to the bus. Each RAM is a power-of-two size that is much smaller than its window, so only the low address bits reach the RAM and the array repeats through the whole window.

The two ports decode differently. The fetch port never reaches the data RAM: a fetch into that window is sent to the bus. The data port may reach both RAMs, which lets it load literals, load code into the instruction RAM and serve debug. Each RAM has an enable bit. The enable bits are loaded from a boot pin while reset is held, and a control write can change them afterwards. A disabled RAM's window goes to the bus. When both ports want the instruction RAM in the same cycle, the data port gets it and the fetch port is stalled for that cycle.

Top module: `tcm_addr_router`

## Requirements
- R1: Address bits [31:26] equal to 0 select the instruction-RAM window (0x0000_0000 to 0x03FF_FFFF). Bits [31:26] equal to 1 select the data-RAM window (0x0400_0000 to 0x07FF_FFFF).
- R2: Any request from either port at 0x0800_0000 or above raises that port's bus request and selects no RAM.
- R3: The RAM-local address is the byte address reduced to log2(RAM size) low bits, so the RAM repeats every RAM-size bytes across its window. A RAM-local address output reads zero while its RAM is not selected.
- R4: A fetch into the data-RAM window raises the fetch bus request, whatever the data-RAM enable is.
- R5: A data-port request to an enabled RAM's window selects that RAM. This holds for both the instruction RAM and the data RAM.
- R6: A request from either port into a disabled RAM's window raises that port's bus request.
- R7: While reset is held, both enable bits take the value of the boot pin `boot_ram_en_i` (1 = enabled).
- R8: With `ctl_wr_i` high at a clock edge, the two enable bits are loaded from `ctl_iram_en_i` and `ctl_dram_en_i`. Routing uses the new values from the next cycle on, and uses the old values in the cycle of the write.
- R9: If both ports target the enabled instruction RAM in the same cycle, the data port's address is sent to the RAM, `iram_dport_o` is 1, and `fetch_stall_o` is 1. The fetch port gets no bus request in that cycle.
- R10: A port with its request low selects no RAM, raises no bus request and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_ram_en_i | input | 1 | Boot value for both RAM enables during reset |
| ctl_wr_i | input | 1 | Control write strobe for the enable bits |
| ctl_iram_en_i | input | 1 | New instruction-RAM enable value |
| ctl_dram_en_i | input | 1 | New data-RAM enable value |
| fetch_req_i | input | 1 | Fetch port request |
| fetch_addr_i | input | ADDR_W | Fetch port byte address |
| data_req_i | input | 1 | Data port request |
| data_addr_i | input | ADDR_W | Data port byte address |
| iram_sel_o | output | 1 | Instruction RAM selected |
| iram_addr_o | output | log2(IRAM_BYTES) | Instruction RAM local address |
| iram_dport_o | output | 1 | Instruction RAM access owned by the data port |
| dram_sel_o | output | 1 | Data RAM selected |
| dram_addr_o | output | log2(DRAM_BYTES) | Data RAM local address |
| fetch_bus_req_o | output | 1 | Fetch request routed to the system bus |
| data_bus_req_o | output | 1 | Data request routed to the system bus |
| fetch_stall_o | output | 1 | Fetch lost instruction-RAM arbitration this cycle |

## Verification
Two things can land in the same cycle. The first is contention: both ports aim at the instruction RAM at once. The second is a control write that changes the enable bits while requests are being routed. The bench provokes contention in two ways: directed pairs of aliased instruction-window addresses, and random traffic that draws both addresses from the instruction window. It checks the stall, the owner flag and the RAM address against the data port. Enable writes are issued in the middle of random traffic, with live requests in the same cycle. The routing in that cycle must follow the old enables and the routing in the next cycle must follow the new ones.

// File: rtl/tcm_router_pkg.sv
package tcm_router_pkg;

   // Routing decision for one port.
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_BUS  = 2'd1,
      TGT_IRAM = 2'd2,
      TGT_DRAM = 2'd3
   } tcm_tgt_e;

   // Window index values taken from the address bits above the window size.
   localparam int unsigned WIN_IDX_IRAM = 0;
   localparam int unsigned WIN_IDX_DRAM = 1;

endpackage

// File: rtl/tcm_port_decode.sv
module tcm_port_decode
   import tcm_router_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WIN_LOG2   = 26,
   parameter bit          FETCH_PORT = 1'b1
) (
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              iram_en_i,
   input  logic              dram_en_i,
   output tcm_tgt_e          tgt_o
);

   localparam int unsigned REGION_W = ADDR_W - WIN_LOG2;

   logic [REGION_W-1:0] region;
   logic                in_iwin;
   logic                in_dwin;

   assign region  = addr_i[ADDR_W-1:WIN_LOG2];
   assign in_iwin = (region == REGION_W'(WIN_IDX_IRAM));
   assign in_dwin = (region == REGION_W'(WIN_IDX_DRAM));

   generate
      if (REGION_W < 2) begin : g_bad_width
         $error("tcm_port_decode: address too narrow for two windows");
      end

      if (FETCH_PORT) begin : g_fetch
         // The fetch port can reach only the instruction RAM.
         always_comb begin
            if (!req_i)                      tgt_o = TGT_NONE;
            else if (in_iwin && iram_en_i)   tgt_o = TGT_IRAM;
            else                             tgt_o = TGT_BUS;
         end
         logic unused_dram_en;
         assign unused_dram_en = dram_en_i ^ in_dwin;
      end else begin : g_data
         // The data port can reach both RAMs.
         always_comb begin
            if (!req_i)                      tgt_o = TGT_NONE;
            else if (in_iwin && iram_en_i)   tgt_o = TGT_IRAM;
            else if (in_dwin && dram_en_i)   tgt_o = TGT_DRAM;
            else                             tgt_o = TGT_BUS;
         end
      end
   endgenerate

endmodule

// File: rtl/tcm_enable_bank.sv
module tcm_enable_bank (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_en_i,
   input  logic wr_i,
   input  logic wr_iram_en_i,
   input  logic wr_dram_en_i,
   output logic iram_en_o,
   output logic dram_en_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iram_en_o <= boot_en_i;
         dram_en_o <= boot_en_i;
      end else if (wr_i) begin
         iram_en_o <= wr_iram_en_i;
         dram_en_o <= wr_dram_en_i;
      end
   end

endmodule

// File: rtl/tcm_iram_arbiter.sv
module tcm_iram_arbiter
   import tcm_router_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned RAM_AW = 14
) (
   input  tcm_tgt_e          fetch_tgt_i,
   input  tcm_tgt_e          data_tgt_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic [ADDR_W-1:0] data_addr_i,
   output logic              sel_o,
   output logic [RAM_AW-1:0] addr_o,
   output logic              dport_o,
   output logic              fetch_stall_o
);

   logic fetch_wants;
   logic data_wants;

   assign fetch_wants = (fetch_tgt_i == TGT_IRAM);
   assign data_wants  = (data_tgt_i  == TGT_IRAM);

   // Fixed priority: the data port always wins.
   always_comb begin
      sel_o         = fetch_wants | data_wants;
      dport_o       = data_wants;
      fetch_stall_o = fetch_wants & data_wants;
      if (data_wants)       addr_o = data_addr_i[RAM_AW-1:0];
      else if (fetch_wants) addr_o = fetch_addr_i[RAM_AW-1:0];
      else                  addr_o = '0;
   end

endmodule

// File: rtl/tcm_addr_router.sv
module tcm_addr_router
   import tcm_router_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WIN_LOG2   = 26,
   parameter int unsigned IRAM_BYTES = 16384,
   parameter int unsigned DRAM_BYTES = 16384,
   localparam int unsigned IRAM_AW   = $clog2(IRAM_BYTES),
   localparam int unsigned DRAM_AW   = $clog2(DRAM_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boot_ram_en_i,
   input  logic               ctl_wr_i,
   input  logic               ctl_iram_en_i,
   input  logic               ctl_dram_en_i,
   input  logic               fetch_req_i,
   input  logic [ADDR_W-1:0]  fetch_addr_i,
   input  logic               data_req_i,
   input  logic [ADDR_W-1:0]  data_addr_i,
   output logic               iram_sel_o,
   output logic [IRAM_AW-1:0] iram_addr_o,
   output logic               iram_dport_o,
   output logic               dram_sel_o,
   output logic [DRAM_AW-1:0] dram_addr_o,
   output logic               fetch_bus_req_o,
   output logic               data_bus_req_o,
   output logic               fetch_stall_o
);

   generate
      if ((IRAM_BYTES & (IRAM_BYTES - 1)) != 0) begin : g_bad_iram_pow2
         $error("tcm_addr_router: IRAM_BYTES must be a power of two");
      end
      if ((DRAM_BYTES & (DRAM_BYTES - 1)) != 0) begin : g_bad_dram_pow2
         $error("tcm_addr_router: DRAM_BYTES must be a power of two");
      end
      if (IRAM_AW > WIN_LOG2 || DRAM_AW > WIN_LOG2) begin : g_bad_size
         $error("tcm_addr_router: RAM larger than its window");
      end
      if (WIN_LOG2 + 2 > ADDR_W) begin : g_bad_addr
         $error("tcm_addr_router: address too narrow for both windows");
      end
   endgenerate

   logic     iram_en;
   logic     dram_en;
   tcm_tgt_e fetch_tgt;
   tcm_tgt_e data_tgt;

   tcm_enable_bank u_enables (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_en_i    (boot_ram_en_i),
      .wr_i         (ctl_wr_i),
      .wr_iram_en_i (ctl_iram_en_i),
      .wr_dram_en_i (ctl_dram_en_i),
      .iram_en_o    (iram_en),
      .dram_en_o    (dram_en)
   );

   tcm_port_decode #(
      .ADDR_W     (ADDR_W),
      .WIN_LOG2   (WIN_LOG2),
      .FETCH_PORT (1'b1)
   ) u_fetch_dec (
      .req_i     (fetch_req_i),
      .addr_i    (fetch_addr_i),
      .iram_en_i (iram_en),
      .dram_en_i (dram_en),
      .tgt_o     (fetch_tgt)
   );

   tcm_port_decode #(
      .ADDR_W     (ADDR_W),
      .WIN_LOG2   (WIN_LOG2),
      .FETCH_PORT (1'b0)
   ) u_data_dec (
      .req_i     (data_req_i),
      .addr_i    (data_addr_i),
      .iram_en_i (iram_en),
      .dram_en_i (dram_en),
      .tgt_o     (data_tgt)
   );

   tcm_iram_arbiter #(
      .ADDR_W (ADDR_W),
      .RAM_AW (IRAM_AW)
   ) u_iram_arb (
      .fetch_tgt_i   (fetch_tgt),
      .data_tgt_i    (data_tgt),
      .fetch_addr_i  (fetch_addr_i),
      .data_addr_i   (data_addr_i),
      .sel_o         (iram_sel_o),
      .addr_o        (iram_addr_o),
      .dport_o       (iram_dport_o),
      .fetch_stall_o (fetch_stall_o)
   );

   // Only the data port reaches the data RAM; the local address keeps the low bits.
   assign dram_sel_o      = (data_tgt == TGT_DRAM);
   assign dram_addr_o     = dram_sel_o ? data_addr_i[DRAM_AW-1:0] : '0;
   assign fetch_bus_req_o = (fetch_tgt == TGT_BUS);
   assign data_bus_req_o  = (data_tgt == TGT_BUS);

endmodule

// File: rtl/tcm_router_checker.sv
module tcm_router_checker #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_LOG2 = 26,
   parameter int unsigned IRAM_AW  = 14,
   parameter int unsigned DRAM_AW  = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctl_wr_i,
   input logic               ctl_iram_en_i,
   input logic               fetch_req_i,
   input logic [ADDR_W-1:0]  fetch_addr_i,
   input logic               data_req_i,
   input logic [ADDR_W-1:0]  data_addr_i,
   input logic               iram_sel_o,
   input logic [IRAM_AW-1:0] iram_addr_o,
   input logic               iram_dport_o,
   input logic               dram_sel_o,
   input logic [DRAM_AW-1:0] dram_addr_o,
   input logic               fetch_bus_req_o,
   input logic               data_bus_req_o,
   input logic               fetch_stall_o
);

   localparam int unsigned REGION_W = ADDR_W - WIN_LOG2;

   logic [REGION_W-1:0] f_region;
   logic [REGION_W-1:0] d_region;
   assign f_region = fetch_addr_i[ADDR_W-1:WIN_LOG2];
   assign d_region = data_addr_i[ADDR_W-1:WIN_LOG2];

   p_above_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_req_i && d_region > REGION_W'(1)) |-> (data_bus_req_o && !dram_sel_o && !iram_dport_o));

   p_fetch_dwin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_i && f_region == REGION_W'(1)) |-> (fetch_bus_req_o && !fetch_stall_o));

   p_dram_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dram_sel_o |-> (d_region == REGION_W'(1) && dram_addr_o == data_addr_i[DRAM_AW-1:0]));

   p_stall_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall_o |-> (iram_sel_o && iram_dport_o && !fetch_bus_req_o
                         && iram_addr_o == data_addr_i[IRAM_AW-1:0]));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_req_i && !data_req_i) |-> (!iram_sel_o && !dram_sel_o && !fetch_bus_req_o
                                         && !data_bus_req_o && !fetch_stall_o));

   p_disable_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && !ctl_iram_en_i) |=> (!(fetch_req_i && f_region == REGION_W'(0)) || fetch_bus_req_o));

endmodule

bind tcm_addr_router tcm_router_checker #(
   .ADDR_W   (ADDR_W),
   .WIN_LOG2 (WIN_LOG2),
   .IRAM_AW  (IRAM_AW),
   .DRAM_AW  (DRAM_AW)
) u_router_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ctl_wr_i        (ctl_wr_i),
   .ctl_iram_en_i   (ctl_iram_en_i),
   .fetch_req_i     (fetch_req_i),
   .fetch_addr_i    (fetch_addr_i),
   .data_req_i      (data_req_i),
   .data_addr_i     (data_addr_i),
   .iram_sel_o      (iram_sel_o),
   .iram_addr_o     (iram_addr_o),
   .iram_dport_o    (iram_dport_o),
   .dram_sel_o      (dram_sel_o),
   .dram_addr_o     (dram_addr_o),
   .fetch_bus_req_o (fetch_bus_req_o),
   .data_bus_req_o  (data_bus_req_o),
   .fetch_stall_o   (fetch_stall_o)
);

// File: tb/test_tcm_addr_router.sv
module test_tcm_addr_router;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 32;
   localparam int IAW = 14;
   localparam int DAW = 14;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           boot_ram_en = 1'b0;
   logic           ctl_wr = 1'b0;
   logic           ctl_iram_en = 1'b0;
   logic           ctl_dram_en = 1'b0;
   logic           fetch_req = 1'b0;
   logic [AW-1:0]  fetch_addr = '0;
   logic           data_req = 1'b0;
   logic [AW-1:0]  data_addr = '0;
   logic           iram_sel, iram_dport, dram_sel, fetch_bus, data_bus, fetch_stall;
   logic [IAW-1:0] iram_addr;
   logic [DAW-1:0] dram_addr;

   int  checks = 0;
   int  errors = 0;
   bit  m_ien = 1'b0;
   bit  m_den = 1'b0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcm_addr_router i_tcm_addr_router (
      .clk             (clk),
      .rst_n           (rst_n),
      .boot_ram_en_i   (boot_ram_en),
      .ctl_wr_i        (ctl_wr),
      .ctl_iram_en_i   (ctl_iram_en),
      .ctl_dram_en_i   (ctl_dram_en),
      .fetch_req_i     (fetch_req),
      .fetch_addr_i    (fetch_addr),
      .data_req_i      (data_req),
      .data_addr_i     (data_addr),
      .iram_sel_o      (iram_sel),
      .iram_addr_o     (iram_addr),
      .iram_dport_o    (iram_dport),
      .dram_sel_o      (dram_sel),
      .dram_addr_o     (dram_addr),
      .fetch_bus_req_o (fetch_bus),
      .data_bus_req_o  (data_bus),
      .fetch_stall_o   (fetch_stall)
   );

   // Reference decode: 0 none, 1 bus, 2 iram, 3 dram.
   function automatic int ref_fetch(bit req, logic [AW-1:0] a, bit ien);
      if (!req) return 0;
      if (a[31:26] == 6'd0 && ien) return 2;
      return 1;
   endfunction

   function automatic int ref_data(bit req, logic [AW-1:0] a, bit ien, bit den);
      if (!req) return 0;
      if (a[31:26] == 6'd0 && ien) return 2;
      if (a[31:26] == 6'd1 && den) return 3;
      return 1;
   endfunction

   function automatic logic [33:0] ref_outputs();
      int ft = ref_fetch(fetch_req, fetch_addr, m_ien);
      int dt = ref_data(data_req, data_addr, m_ien, m_den);
      logic [IAW-1:0] ia = (dt == 2) ? data_addr[IAW-1:0] : (ft == 2) ? fetch_addr[IAW-1:0] : '0;
      logic [DAW-1:0] da = (dt == 3) ? data_addr[DAW-1:0] : '0;
      return {(ft == 2 || dt == 2), ia, (dt == 2), (dt == 3), da,
              (ft == 1), (dt == 1), (ft == 2 && dt == 2)};
   endfunction

   task automatic check(string tag);
      logic [33:0] act = {iram_sel, iram_addr, iram_dport, dram_sel, dram_addr,
                          fetch_bus, data_bus, fetch_stall};
      logic [33:0] exp = ref_outputs();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s fa=%h da=%h act=%h exp=%h", tag, fetch_addr, data_addr, act, exp);
      end
   endtask

   task automatic apply(bit fr, logic [AW-1:0] fa, bit dr, logic [AW-1:0] da, string tag);
      @(negedge clk);
      fetch_req = fr; fetch_addr = fa; data_req = dr; data_addr = da;
      #1 check(tag);
   endtask

   // Write the enables; the write-cycle routing must use the old values.
   task automatic ctl_write(bit ie, bit de, string tag);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_iram_en = ie; ctl_dram_en = de;
      #1 check({tag, " R8 old"});
      @(posedge clk);
      m_ien = ie; m_den = de;
      @(negedge clk);
      ctl_wr = 1'b0;
      #1 check({tag, " R8 new"});
   endtask

   task automatic do_reset(bit boot);
      @(negedge clk);
      rst_n = 1'b0; boot_ram_en = boot; ctl_wr = 1'b0;
      repeat (2) @(posedge clk);
      m_ien = boot; m_den = boot;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [AW-1:0] rand_addr();
      int unsigned cat = $urandom % 6;
      logic [AW-1:0] r = $urandom;
      case (cat)
         0: return {6'd0, r[25:0]};
         1: return {6'd1, r[25:0]};
         2: return {r[31:27] | 5'd1, r[26:0]};
         3: return 32'h07FF_FFFC + 32'(r[2:0]);
         4: return 32'h03FF_FFFC + 32'(r[2:0]);
         default: return r;
      endcase
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset(1'b0);
      // R7: boot pin low leaves both RAMs off.
      apply(1, 32'h0000_0010, 1, 32'h0400_0020, "R7 boot low");
      ctl_write(1, 1, "enable both");
      apply(1, 32'h03FF_FFFF, 1, 32'h0400_0000, "R1 window edges");
      apply(1, 32'h0800_0000, 1, 32'h0800_0000, "R2 128MB");
      apply(1, 32'hFFFF_FFFC, 1, 32'h07FF_FFFF, "R2 top / R1 dram end");
      apply(1, 32'h0400_0000, 0, 32'h0, "R4 fetch dwin");
      apply(1, 32'h03FF_C123, 1, 32'h0400_4005, "R3 alias");
      apply(0, 32'h0, 1, 32'h0000_0100, "R5 data to iram");
      apply(1, 32'h0000_4008, 1, 32'h03FF_C00C, "R9 contention");
      apply(0, 32'h0000_0040, 0, 32'h0400_0040, "R10 idle");
      ctl_write(0, 1, "iram off");
      apply(1, 32'h0000_0010, 1, 32'h0000_0020, "R6 iram off");
      apply(1, 32'h0400_0010, 1, 32'h0400_0030, "R4 dram on, R5");
      ctl_write(1, 0, "dram off");
      apply(1, 32'h0400_0010, 1, 32'h0400_0030, "R6 dram off / R4");
      ctl_write(1, 1, "enable both again");
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 40 == 0) begin
            @(negedge clk);
            fetch_req = $urandom; fetch_addr = rand_addr();
            data_req = $urandom; data_addr = rand_addr();
            ctl_write($urandom, $urandom, "R8 rand");
         end else if ($urandom % 8 == 0) begin
            logic [AW-1:0] r1 = $urandom;
            logic [AW-1:0] r2 = $urandom;
            apply(1, {6'd0, r1[25:0]}, 1, {6'd0, r2[25:0]}, "R9 rand");
         end else begin
            apply($urandom, rand_addr(), $urandom, rand_addr(), "R1-mix rand");
         end
      end
      do_reset(1'b1);
      apply(1, 32'h0000_0004, 1, 32'h0400_0008, "R7 boot high");
      finish_run();
   end

endmodule